// File: doc/BRIEF.md
# Auto-Reloading Decrementer Timer

This block is a down-counting timer that loses one count on every enabled time-base tick. When the count runs out it raises a sticky status flag. That flag, gated by an enable bit in a control word, drives an interrupt line to the processor. Software clears the flag by writing a one to its position in the status word.

In the control word, one bit arms the interrupt and another turns on automatic restart. With automatic restart on, an expiry loads the counter from a separate reload register, so the timer runs periodically. With automatic restart off, the counter parks at zero. It then stays idle until software writes a new count.

Software has write strobes for the counter, the reload register, the control word and the status word. It can read the live count and the status word. Tick generation lives outside the block and arrives as a one-cycle tick-enable input.

Top module: `dec_timer_top`

## Requirements
- R1: After reset the count, the reload value, the status flag and both control bits are zero, and `irq_o` is low.
- R2: In a cycle with `tick_en` high, a count above one drops by one at the next clock edge. With `tick_en` low and no counter write, the count holds.
- R3: A tick taken while the count is one is an expiry. The status flag (bit 27 of `sts_rdata_o`) reads one from the next cycle on, whether it was set before or not.
- R4: With automatic restart off (control bit 22 clear), a count of zero stays at zero under ticks and produces no further expiry.
- R5: With automatic restart on (control bit 22 set), an expiry loads the counter from the reload register instead of zero.
- R6: With automatic restart on, a tick taken while the count is zero is also an expiry. A reload value of zero therefore expires on every tick.
- R7: A counter write (`cnt_we_i`) loads `cnt_wdata_i` and overrides decrement and reload in the same cycle. No expiry occurs in that cycle.
- R8: A status write clears the flag when `sts_wdata_i` bit 27 is one and leaves it alone when that bit is zero. An expiry in the same cycle wins and the flag stays set. All other bits of `sts_rdata_o` read zero.
- R9: `irq_o` is high exactly when the status flag is set and control bit 26 (interrupt enable) is set.
- R10: Control write bits other than 26 and 22 have no effect: they neither enable the interrupt nor turn on automatic restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en_i | input | 1 | Time-base tick, one cycle per count |
| cnt_we_i | input | 1 | Counter write strobe |
| cnt_wdata_i | input | CNT_W | New count value |
| rld_we_i | input | 1 | Reload register write strobe |
| rld_wdata_i | input | CNT_W | New reload value |
| ctl_we_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | REG_W | Control word (bit 26 interrupt enable, bit 22 automatic restart) |
| sts_we_i | input | 1 | Status write-one-to-clear strobe |
| sts_wdata_i | input | REG_W | Status clear mask (bit 27 clears the flag) |
| count_o | output | CNT_W | Current count |
| sts_rdata_o | output | REG_W | Status word, flag at bit 27 |
| irq_o | output | 1 | Decrementer interrupt request |

## Verification
The bench targets the transitions where the count is one or zero.

- A design that triggers expiry at the wrong count either fires one tick early or never fires from a parked zero.
- A design that lets a reload overrule a simultaneous software write loses the value software just wrote.
- A reload value of zero with automatic restart on must expire on every tick. A design that only watches the one-to-zero edge stalls after the first expiry.
- An expiry that coincides with a clear must leave the flag set. Getting this wrong drops an interrupt.
- Noise bits in the control word must not switch on restart or the interrupt.

// File: rtl/dec_pkg.sv
package dec_pkg;
  localparam int unsigned CTL_IRQ_EN_BIT  = 26;
  localparam int unsigned CTL_AUTO_RLD_BIT = 22;
  localparam int unsigned STS_FLAG_BIT    = 27;

  typedef struct packed {
    logic irq_en;
    logic auto_rld;
  } dec_ctl_t;
endpackage

// File: rtl/dec_ctl_reg.sv
module dec_ctl_reg
  import dec_pkg::*;
#(
  parameter int unsigned REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output dec_ctl_t         ctl_o
);
  dec_ctl_t ctl_q;
  logic     unused_wdata;

  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (we_i) begin
      ctl_q.irq_en   <= wdata_i[CTL_IRQ_EN_BIT];
      ctl_q.auto_rld <= wdata_i[CTL_AUTO_RLD_BIT];
    end
  end

  assign ctl_o = ctl_q;

  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(ctl_q)); // R10
endmodule

// File: rtl/dec_counter.sv
module dec_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             rld_we_i,
  input  logic [CNT_W-1:0] rld_wdata_i,
  input  logic             auto_rld_i,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] rld_q;
  logic [CNT_W-1:0] count_d;
  logic             expire;

  // A tick expires the counter when it takes the count from one to zero,
  // or when it lands on a parked zero while automatic restart is armed.
  function automatic logic fn_expires(input logic [CNT_W-1:0] cnt,
                                      input logic tick, input logic wr,
                                      input logic rld_on);
    fn_expires = !wr && tick && ((cnt == ONE) || ((cnt == '0) && rld_on));
  endfunction

  function automatic logic [CNT_W-1:0] fn_step(input logic [CNT_W-1:0] cnt);
    fn_step = (cnt == '0) ? cnt : cnt - ONE;
  endfunction

  assign expire = fn_expires(count_q, tick_en_i, cnt_we_i, auto_rld_i);

  always_comb begin
    count_d = count_q;
    if (cnt_we_i)        count_d = cnt_wdata_i;
    else if (expire)     count_d = auto_rld_i ? rld_q : '0;
    else if (tick_en_i)  count_d = fn_step(count_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      rld_q   <= '0;
    end else begin
      count_q <= count_d;
      if (rld_we_i) rld_q <= rld_wdata_i;
    end
  end

  assign count_o  = count_q;
  assign expire_o = expire;

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we_i |=> count_q == $past(cnt_wdata_i)); // R7
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en_i && !cnt_we_i) |=> $stable(count_q)); // R2
  AST_PARK_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == '0 && !auto_rld_i && !cnt_we_i) |=> count_q == '0); // R4
  AST_RELOAD_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && auto_rld_i) |=> count_q == $past(rld_q)); // R5
endmodule

// File: rtl/dec_status.sv
module dec_status
  import dec_pkg::*;
#(
  parameter int unsigned REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             expire_i,
  input  logic             clr_we_i,
  input  logic [REG_W-1:0] clr_wdata_i,
  input  logic             irq_en_i,
  output logic [REG_W-1:0] sts_rdata_o,
  output logic             irq_o
);
  logic flag_q;
  logic clr_hit;
  logic unused_mask;

  assign unused_mask = ^clr_wdata_i;
  assign clr_hit     = clr_we_i && clr_wdata_i[STS_FLAG_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n)         flag_q <= 1'b0;
    else if (expire_i)  flag_q <= 1'b1;
    else if (clr_hit)   flag_q <= 1'b0;
  end

  always_comb begin
    sts_rdata_o               = '0;
    sts_rdata_o[STS_FLAG_BIT] = flag_q;
  end

  assign irq_o = flag_q && irq_en_i;

  AST_EXPIRY_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    expire_i |=> flag_q); // R3
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && !expire_i) |=> !flag_q); // R8
  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ($past(expire_i) || $rose(irq_en_i))); // R9
endmodule

// File: rtl/dec_timer_top.sv
module dec_timer_top
  import dec_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             rld_we_i,
  input  logic [CNT_W-1:0] rld_wdata_i,
  input  logic             ctl_we_i,
  input  logic [REG_W-1:0] ctl_wdata_i,
  input  logic             sts_we_i,
  input  logic [REG_W-1:0] sts_wdata_i,
  output logic [CNT_W-1:0] count_o,
  output logic [REG_W-1:0] sts_rdata_o,
  output logic             irq_o
);
  dec_ctl_t ctl;
  logic     expire;

  dec_ctl_reg #(.REG_W(REG_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .we_i(ctl_we_i), .wdata_i(ctl_wdata_i),
    .ctl_o(ctl)
  );

  dec_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en_i(tick_en_i),
    .cnt_we_i(cnt_we_i), .cnt_wdata_i(cnt_wdata_i),
    .rld_we_i(rld_we_i), .rld_wdata_i(rld_wdata_i),
    .auto_rld_i(ctl.auto_rld), .count_o(count_o), .expire_o(expire)
  );

  dec_status #(.REG_W(REG_W)) u_sts (
    .clk(clk), .rst_n(rst_n), .expire_i(expire),
    .clr_we_i(sts_we_i), .clr_wdata_i(sts_wdata_i),
    .irq_en_i(ctl.irq_en), .sts_rdata_o(sts_rdata_o), .irq_o(irq_o)
  );

  AST_NO_TICK_NO_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en_i |=> !$rose(sts_rdata_o[STS_FLAG_BIT])); // R3
endmodule

// File: tb/test_dec_timer_top.sv
module test_dec_timer_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;
  localparam logic [31:0] FLAG = 32'h1 << 27;
  localparam logic [31:0] IEN  = 32'h1 << 26;
  localparam logic [31:0] ARL  = 32'h1 << 22;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0, cnt_we = 1'b0, rld_we = 1'b0, ctl_we = 1'b0, sts_we = 1'b0;
  logic [31:0] cnt_wd = '0, rld_wd = '0, ctl_wd = '0, sts_wd = '0;
  logic [31:0] count, sts_rd;
  logic irq;

  int checks = 0, fails = 0;
  bit done = 0;

  // bench-side reference state
  logic [31:0] m_cnt = '0, m_rld = '0;
  logic m_flag = 0, m_ien = 0, m_arl = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dec_timer_top i_dec_timer_top (
    .clk(clk), .rst_n(rst_n), .tick_en_i(tick_en),
    .cnt_we_i(cnt_we), .cnt_wdata_i(cnt_wd),
    .rld_we_i(rld_we), .rld_wdata_i(rld_wd),
    .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wd),
    .sts_we_i(sts_we), .sts_wdata_i(sts_wd),
    .count_o(count), .sts_rdata_o(sts_rd), .irq_o(irq)
  );

  function automatic bit ref_fires(logic [31:0] c, bit t, bit w, bit a);
    if (w || !t) return 0;
    if (c == 32'd1) return 1;
    return (c == 32'd0) && a;
  endfunction

  function automatic logic [31:0] ref_count(logic [31:0] c, bit t, bit w,
                                             logic [31:0] wd, bit a, logic [31:0] r);
    if (w) return wd;
    if (ref_fires(c, t, w, a)) return a ? r : 32'd0;
    if (t && c != 0) return c - 32'd1;
    return c;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(bit t, bit cw, logic [31:0] cd, bit rw, logic [31:0] rd,
                      bit kw, logic [31:0] kd, bit sw, logic [31:0] sd);
    bit fire;
    @(negedge clk);
    tick_en = t; cnt_we = cw; cnt_wd = cd; rld_we = rw; rld_wd = rd;
    ctl_we = kw; ctl_wd = kd; sts_we = sw; sts_wd = sd;
    fire = ref_fires(m_cnt, t, cw, m_arl);
    @(posedge clk);
    #1;
    m_cnt  = ref_count(m_cnt, t, cw, cd, m_arl, m_rld);
    m_flag = fire ? 1'b1 : ((sw && sd[27]) ? 1'b0 : m_flag);
    if (rw) m_rld = rd;
    if (kw) begin m_ien = kd[26]; m_arl = kd[22]; end
  endtask

  task automatic idle();               step(0,0,0,0,0,0,0,0,0); endtask
  task automatic tick();               step(1,0,0,0,0,0,0,0,0); endtask
  task automatic wcnt(logic [31:0] v); step(0,1,v,0,0,0,0,0,0); endtask
  task automatic wrld(logic [31:0] v); step(0,0,0,1,v,0,0,0,0); endtask
  task automatic wctl(logic [31:0] v); step(0,0,0,0,0,1,v,0,0); endtask
  task automatic wsts(logic [31:0] v); step(0,0,0,0,0,0,0,1,v); endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R1 count", count, 0);
    chk("R1 status", sts_rd, 0);
    chk("R1 irq", {31'd0, irq}, 0);

    // R2 decrement and hold
    wcnt(5); idle(); idle(); idle();
    chk("R2 hold without tick", count, 5);
    tick(); chk("R2 decrement", count, 4);

    // R3 expiry at one
    tick(); tick(); tick(); chk("R3 count at one", count, 1);
    tick(); chk("R3 count zero", count, 0);
    chk("R3 flag set", sts_rd, FLAG);

    // R4 parked without restart
    wsts(FLAG); chk("R8 clear", sts_rd, 0);
    repeat (4) tick();
    chk("R4 stays zero", count, 0);
    chk("R4 no re-expiry", sts_rd, 0);

    // R3 sets regardless of previous value
    wcnt(1); tick(); wcnt(1); tick();
    chk("R3 flag already set stays set", sts_rd, FLAG);

    // R9 interrupt gating
    chk("R9 irq off without enable", {31'd0, irq}, 0);
    wctl(IEN); chk("R9 irq on", {31'd0, irq}, 1);
    wsts(FLAG); chk("R9 irq drops with flag", {31'd0, irq}, 0);

    // R10 noise bits in control word
    wrld(9);
    wctl(~(IEN | ARL));
    wcnt(1); tick();
    chk("R10 no reload from noise", count, 0);
    chk("R10 flag set", sts_rd, FLAG);
    chk("R10 irq stays low", {31'd0, irq}, 0);

    // R5 reload on expiry
    wctl(IEN | ARL); wsts(FLAG);
    wcnt(2); tick(); tick();
    chk("R5 reloaded", count, 9);
    chk("R5 flag", sts_rd, FLAG);
    chk("R9 irq with enable", {31'd0, irq}, 1);

    // R7 write beats decrement/reload
    wsts(FLAG); wcnt(1);
    step(1,1,6,0,0,0,0,0,0);
    chk("R7 write over expiry", count, 6);
    chk("R7 no expiry on write", sts_rd, 0);

    // R6 reload zero expires every tick
    wrld(0); wcnt(0);
    tick(); chk("R6 expiry at zero", sts_rd, FLAG);
    chk("R6 count zero", count, 0);
    wsts(FLAG); chk("R6 cleared", sts_rd, 0);
    tick(); chk("R6 expiry again", sts_rd, FLAG);

    // R8 clear semantics
    wsts(~FLAG); chk("R8 zero bit no clear", sts_rd, FLAG);
    step(1,0,0,0,0,0,0,1,FLAG);
    chk("R8 expiry beats clear", sts_rd, FLAG);
    wsts(FLAG); chk("R8 clear after", sts_rd, 0);

    // Random phase
    for (int i = 0; i < 3000; i++) begin
      bit t  = ($urandom_range(0,3) != 0);
      bit cw = ($urandom_range(0,9) == 0);
      bit rw = ($urandom_range(0,15) == 0);
      bit kw = ($urandom_range(0,19) == 0);
      bit sw = ($urandom_range(0,5) == 0);
      logic [31:0] kd = $urandom() & ~(IEN | ARL);
      if ($urandom_range(0,1) != 0) kd |= IEN;
      if ($urandom_range(0,1) != 0) kd |= ARL;
      step(t, cw, $urandom_range(0,6), rw, $urandom_range(0,5), kw, kd,
           sw, ($urandom_range(0,1) != 0) ? FLAG : 32'h0);
      chk("R2 random count", count, m_cnt);
      chk("R8 random status", sts_rd, m_flag ? FLAG : 32'h0);
      chk("R9 random irq", {31'd0, irq}, {31'd0, m_flag && m_ien});
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule